// File: doc/BRIEF.md
# Half-Duplex Synchronous Serial Master

This block is the master end of a byte-wide synchronous serial link. It uses a single bidirectional data line for both directions and has two port-select outputs. A host starts a transfer with a one-cycle write request. The request carries the direction (send or fetch a byte), the target port and a clock divisor. The block then asserts the chosen port select, which is active high and idles low. It runs exactly eight serial clock cycles, with the serial clock idling high, and shifts the byte out MSB first or samples it in. Finally it drops the select and raises a one-cycle completion pulse.

During a send, the data line is driven from the first falling serial clock edge until the select drops. During a fetch, the line is never driven. The block samples it on each rising serial clock edge and latches the assembled byte into a readable output when the transfer finishes. A request made while a transfer is running is discarded and sets a sticky overrun flag. A test input turns off the output enables of the serial clock and port-select pins.

Top module: `hdx_serial_master`

## Requirements
- R1: With `host_div` = d, every serial clock half period lasts 2^d system clocks (d=0..3 gives division by 2, 4, 8, 16). The divisor is captured with the request.
- R2: Each accepted request (`host_wr` high while not busy) produces exactly eight rising serial clock edges, and `sclk_o` changes only while `busy` is high.
- R3: `sclk_o` is high out of reset and whenever no transfer is running.
- R4: During a transfer, only `sel_o[host_port]` is high (port 0 maps to bit 0). Both bits are low while idle.
- R5: The select rises on the clock edge that accepts the request. The first serial clock falling edge comes one half period later, and the select falls one half period after the eighth rising edge. A transfer therefore spans 17 half periods from the accepting edge to the select falling.
- R6: With `host_op` = 0 (send), `host_txbyte` leaves MSB first. Each bit changes on a serial clock falling edge and is stable at the following rising edge. `sdata_oe` is high from the first falling edge until the select falls.
- R7: With `host_op` = 1 (fetch), `sdata_oe` stays low for the whole transfer. `sdata_i` is sampled on each rising edge, first bit into the MSB. The byte appears on `rx_byte` when `done` pulses. A send leaves `rx_byte` unchanged.
- R8: `busy` is high from the accepting edge until the select falls. `done` is high for exactly one clock, in the cycle where the select has just fallen.
- R9: `host_wr` while busy does not alter the running transfer. It sets `err`, which stays high until `host_clr_err` is asserted on a cycle without a new overrun.
- R10: While `hiz_i` is high, `sclk_oe` and `sel_oe` are low. Otherwise they are high.
- R11: After synchronous reset, `busy`, `done`, `err`, `sel_o`, `sdata_oe` and `rx_byte` are zero and `sclk_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | One-cycle transfer request |
| host_op | input | 1 | 0 = send byte, 1 = fetch byte |
| host_port | input | 1 | Target port select index |
| host_div | input | 2 | Half period = 2^host_div clocks |
| host_txbyte | input | 8 | Byte to send |
| host_clr_err | input | 1 | Clears the overrun flag |
| hiz_i | input | 1 | Test input that releases clock and select pins |
| sdata_i | input | 1 | Data line as seen at the pin |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Last fetched byte |
| err | output | 1 | Sticky overrun flag |
| sclk_o | output | 1 | Serial clock value |
| sclk_oe | output | 1 | Serial clock output enable |
| sel_o | output | 2 | Active-high port selects |
| sel_oe | output | 1 | Port select output enable |
| sdata_o | output | 1 | Data line drive value |
| sdata_oe | output | 1 | Data line drive enable |

## Verification
Several properties are checked on every cycle: the serial clock idles high and moves only while busy, at most one select is high and the selects agree with `busy`, the data line is released when idle, and `done` is a single cycle that follows busy. The overrun flag is also checked every cycle, both for being set and for staying set. Other behaviour can only be shown by the bench scenarios. These cover the transfer length for every divisor, the exact edge count, the bit order on the line and the received byte, the data line staying undriven during a fetch, and an intruding request leaving a running burst untouched.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
    localparam int HDX_DIVW = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL
    } hdx_state_e;

    typedef enum logic {
        OP_SEND  = 1'b0,
        OP_FETCH = 1'b1
    } hdx_op_e;

    typedef struct packed {
        hdx_op_e               op;
        logic                  port;
        logic [HDX_DIVW-1:0]   div;
    } hdx_req_t;

    // clocks per half serial period minus one, for a divisor code
    function automatic int unsigned half_last(logic [HDX_DIVW-1:0] d);
        return (32'd1 << d) - 32'd1;
    endfunction
endpackage

// File: rtl/hdx_tick.sv
module hdx_tick
    import hdx_pkg::*;
#(
    parameter int DIVW = HDX_DIVW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    localparam int CW = (1 << DIVW) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = CW'(half_last(div));
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hdx_shreg.sv
module hdx_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shl,
    input  logic         smp,
    input  logic         sin,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= din;
        else if (shl)  q <= {q[W-2:0], 1'b0};
        else if (smp)  q <= {q[W-2:0], sin};
    end
endmodule

// File: rtl/hdx_seq.sv
module hdx_seq
    import hdx_pkg::*;
#(
    parameter int NBITS = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  hdx_req_t req,
    input  logic     tick,
    output hdx_req_t cur,
    output logic     busy,
    output logic     sclk,
    output logic [1:0] sel,
    output logic     data_oe,
    output logic     done,
    output logic     rise,
    output logic     fall_mid,
    output logic     last
);
    localparam int BCW = $clog2(NBITS + 1);

    hdx_state_e     state;
    logic [BCW-1:0] bitcnt;

    assign busy     = (state != ST_IDLE);
    assign rise     = tick && (state == ST_SHIFT) && !sclk;
    assign fall_mid = tick && (state == ST_SHIFT) && sclk;
    assign last     = tick && (state == ST_TAIL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur     <= '0;
            sclk    <= 1'b1;
            sel     <= 2'b00;
            data_oe <= 1'b0;
            done    <= 1'b0;
            bitcnt  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    cur    <= req;
                    sel    <= req.port ? 2'b10 : 2'b01;
                    bitcnt <= '0;
                    state  <= ST_LEAD;
                end
                ST_LEAD: if (tick) begin
                    sclk    <= 1'b0;
                    data_oe <= (cur.op == OP_SEND);
                    state   <= ST_SHIFT;
                end
                ST_SHIFT: if (tick) begin
                    if (!sclk) begin
                        sclk   <= 1'b1;
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == BCW'(NBITS - 1)) state <= ST_TAIL;
                    end else begin
                        sclk <= 1'b0;
                    end
                end
                ST_TAIL: if (tick) begin
                    sel     <= 2'b00;
                    data_oe <= 1'b0;
                    done    <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hdx_serial_master.sv
module hdx_serial_master
    import hdx_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int DIVW  = HDX_DIVW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic             host_op,
    input  logic             host_port,
    input  logic [DIVW-1:0]  host_div,
    input  logic [NBITS-1:0] host_txbyte,
    input  logic             host_clr_err,
    input  logic             hiz_i,
    input  logic             sdata_i,
    output logic             busy,
    output logic             done,
    output logic [NBITS-1:0] rx_byte,
    output logic             err,
    output logic             sclk_o,
    output logic             sclk_oe,
    output logic [1:0]       sel_o,
    output logic             sel_oe,
    output logic             sdata_o,
    output logic             sdata_oe
);
    hdx_req_t         req, cur;
    logic             start, tick, rise, fall_mid, last;
    logic [NBITS-1:0] shq;

    assign req   = '{op: hdx_op_e'(host_op), port: host_port, div: host_div};
    assign start = host_wr && !busy;

    hdx_tick #(.DIVW(DIVW)) tick_i (
        .clk(clk), .rst(rst), .run(busy), .div(cur.div), .tick(tick)
    );

    hdx_seq #(.NBITS(NBITS)) seq_i (
        .clk(clk), .rst(rst), .start(start), .req(req), .tick(tick),
        .cur(cur), .busy(busy), .sclk(sclk_o), .sel(sel_o),
        .data_oe(sdata_oe), .done(done), .rise(rise),
        .fall_mid(fall_mid), .last(last)
    );

    hdx_shreg #(.W(NBITS)) shreg_i (
        .clk(clk), .rst(rst), .load(start), .din(host_txbyte),
        .shl(fall_mid && (cur.op == OP_SEND)),
        .smp(rise && (cur.op == OP_FETCH)),
        .sin(sdata_i), .q(shq)
    );

    assign sdata_o = shq[NBITS-1];
    assign sclk_oe = !hiz_i;
    assign sel_oe  = !hiz_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte <= '0;
            err     <= 1'b0;
        end else begin
            if (last && (cur.op == OP_FETCH)) rx_byte <= shq;
            if (host_wr && busy)   err <= 1'b1;
            else if (host_clr_err) err <= 1'b0;
        end
    end
endmodule

// File: rtl/hdx_master_chk.sv
module hdx_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_wr,
    input logic       host_clr_err,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       sclk_o,
    input logic [1:0] sel_o,
    input logic       sdata_oe
);
    a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sclk_o);
    a_r2_sclk_moves_in_burst: assert property (@(posedge clk) disable iff (rst)
        !$stable(sclk_o) |-> busy);
    a_r4_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o));
    a_r8_sel_implies_busy: assert property (@(posedge clk) disable iff (rst)
        (sel_o != 2'b00) |-> busy);
    a_r8_busy_implies_sel: assert property (@(posedge clk) disable iff (rst)
        busy |-> (sel_o != 2'b00));
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
    a_r7_release_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sdata_oe);
    a_r9_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        (host_wr && busy) |=> err);
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err && !host_clr_err) |=> err);
endmodule

bind hdx_serial_master hdx_master_chk chk_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_clr_err(host_clr_err),
    .busy(busy), .done(done), .err(err), .sclk_o(sclk_o), .sel_o(sel_o),
    .sdata_oe(sdata_oe)
);

// File: tb/hdx_serial_master_tb_top.sv
module hdx_serial_master_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0, host_op = 1'b0, host_port = 1'b0;
    logic [1:0] host_div = 2'd0;
    logic [7:0] host_txbyte = 8'h00;
    logic       host_clr_err = 1'b0, hiz_i = 1'b0, sdata_i = 1'b0;
    logic       busy, done, err, sclk_o, sclk_oe, sel_oe, sdata_o, sdata_oe;
    logic [7:0] rx_byte;
    logic [1:0] sel_o;

    hdx_serial_master dut_i (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // slave and line monitors
    int         rises = 0, sl_idx = 7;
    logic [7:0] cap = 8'h00, sl_byte = 8'h00;
    logic [1:0] exp_sel = 2'b00;
    bit         sel_bad = 0, oe_bad = 0, cur_rx = 0;

    always @(posedge sclk_o) if (sel_o != 2'b00) begin
        rises = rises + 1;
        cap   = {cap[6:0], sdata_o};
    end

    always @(negedge sclk_o) if (sel_o != 2'b00 && sl_idx >= 0) begin
        sdata_i <= sl_byte[sl_idx];
        sl_idx  = sl_idx - 1;
    end

    always @(negedge clk) if (busy === 1'b1) begin
        if (sel_o !== exp_sel) sel_bad = 1;
        if (cur_rx && sdata_oe) oe_bad = 1;
    end

    // {op, port, div[1:0], txbyte, slave byte}
    localparam logic [19:0] VEC [7] = '{
        20'h0_A5_00, 20'hC_00_3C, 20'h5_81_00, 20'hA_00_C6,
        20'h3_5E_00, 20'hF_00_7B, 20'h6_01_00
    };

    task automatic run_xfer(input bit op, input bit port, input logic [1:0] div,
                            input logic [7:0] tx, input logic [7:0] sl,
                            input int inj, output int cyc);
        @(negedge clk);
        rises = 0; cap = 8'h00; sl_byte = sl; sl_idx = 7;
        exp_sel = port ? 2'b10 : 2'b01; cur_rx = op;
        sel_bad = 0; oe_bad = 0;
        host_wr = 1'b1; host_op = op; host_port = port;
        host_div = div; host_txbyte = tx;
        @(negedge clk);
        host_wr = 1'b0;
        cyc = 1;
        while (done !== 1'b1 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (cyc == inj) begin
                host_wr = 1'b1; host_port = ~port; host_op = ~op;
                host_div = 2'd0; host_txbyte = ~tx;
            end else begin
                host_wr = 1'b0;
            end
        end
        host_wr = 1'b0;
    endtask

    initial begin : watchdog
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int cyc;
        int h;
        logic [7:0] last_rx;
        last_rx = 8'h00;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(busy === 0 && done === 0 && err === 0, "R11 idle flags", {busy, done, err}, 0);
        chk(sel_o === 2'b00 && sdata_oe === 0, "R11 selects/oe", {sel_o, sdata_oe}, 0);
        chk(rx_byte === 8'h00, "R11 rx_byte", rx_byte, 0);
        chk(sclk_o === 1'b1, "R3 sclk idle high", sclk_o, 1);
        chk(sclk_oe === 1 && sel_oe === 1, "R10 enables on", {sclk_oe, sel_oe}, 3);

        foreach (VEC[i]) begin
            h = 1 << VEC[i][17:16];
            run_xfer(VEC[i][19], VEC[i][18], VEC[i][17:16], VEC[i][15:8], VEC[i][7:0], 0, cyc);
            // R1 R5: done seen 17 half periods after the accepting edge
            chk(cyc == 17 * h + 1, "R1 R5 transfer length", cyc, 17 * h + 1);
            chk(rises == 8, "R2 eight rising edges", rises, 8);
            chk(!sel_bad, "R4 only selected port", exp_sel, exp_sel);
            if (VEC[i][19]) begin
                last_rx = VEC[i][7:0];
                chk(!oe_bad, "R7 line released on fetch", 1, 0);
            end else begin
                chk(cap === VEC[i][15:8], "R6 MSB-first send", cap, VEC[i][15:8]);
            end
            chk(rx_byte === last_rx, "R7 rx_byte", rx_byte, last_rx);
            chk(busy === 0 && sel_o === 2'b00 && sdata_oe === 0, "R8 end state", {busy, sel_o, sdata_oe}, 0);
            @(negedge clk);
            chk(done === 0, "R8 done one cycle", done, 0);
            chk(sclk_o === 1, "R3 sclk high after burst", sclk_o, 1);
        end

        // R9 overrun: intruding request mid-burst
        run_xfer(1'b0, 1'b0, 2'd1, 8'h96, 8'h00, 6, cyc);
        chk(cyc == 35, "R9 burst length unaffected", cyc, 35);
        chk(cap === 8'h96, "R9 data unaffected", cap, 8'h96);
        chk(!sel_bad, "R9 port unaffected", 0, 0);
        chk(rises == 8, "R9 edge count unaffected", rises, 8);
        chk(err === 1, "R9 err set", err, 1);
        repeat (4) @(negedge clk);
        chk(err === 1, "R9 err sticky", err, 1);
        chk(busy === 0, "R9 no extra transfer", busy, 0);
        host_clr_err = 1'b1;
        @(negedge clk);
        host_clr_err = 1'b0;
        chk(err === 0, "R9 err cleared", err, 0);

        // R10 test-mode release
        hiz_i = 1'b1;
        @(negedge clk);
        chk(sclk_oe === 0 && sel_oe === 0, "R10 hiz releases pins", {sclk_oe, sel_oe}, 0);
        hiz_i = 1'b0;
        @(negedge clk);
        chk(sclk_oe === 1 && sel_oe === 1, "R10 pins driven again", {sclk_oe, sel_oe}, 3);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule